// File: doc/BRIEF.md
# Audio Coprocessor Bus Decoder

This block sits between the 8-bit audio coprocessor core and everything that core can address. Each bus operation is started with a one-cycle request. The block captures the address and write data, runs the operation over a fixed number of clocks, and routes it to one of three targets: work RAM, a 64-byte boot ROM that overlays the top of the address space for reads only, or a page of sixteen control registers at 0x00F0–0x00FF.

The control page holds the block's own state. This covers a configuration byte, a control byte, an indirect index and data window into a 128-entry sound register file, four host mailbox ports in each direction, and two scratch bytes. Timer targets and timer count reads are passed through to an external timer block as strobes. Every write is also offered to RAM, including writes to the control page. RAM access can be gated or blanked by configuration bits.

Top module: `apu_bus_decoder`

## Requirements
- R1: An operation is accepted when `op_start` is high and `busy` is low. `busy` then stays high for exactly 24 cycles, whatever the kind (`op_kind` 0 internal, 1 read, 2 write, 3 treated as internal). `done` is high in the last of those cycles, and `op_start` is ignored while `busy` is high.
- R2: A read result appears on `rdata` after the 12th busy cycle and holds until the next read. A write takes effect at the end of the 24th busy cycle, with its strobe (`ram_we`, `snd_we`, `tgt_we`) high during that cycle only.
- R3: While the overlay enable is set (reset value 1), reads of 0xFFC0–0xFFFF return `rom_data` for `rom_idx` = address bits 5:0. While it is clear, they return RAM data.
- R4: Writes to 0xFFC0–0xFFFF go to RAM whether or not the overlay is enabled.
- R5: Configuration bit 2 blanks RAM: RAM reads return 0x5A. A RAM write is issued only when bit 1 (writable) is set and bit 2 is clear. Reset gives writable 1 and blank 0.
- R6: Every bus write, including a write to the control page, is offered to RAM with the same address and data.
- R7: A write to 0x00F0 loads the configuration, unless `p_flag` is high, in which case it is ignored. The fields are bits 7:6 clock speed, 5:4 timer speed, 3 timers enable (reset 1), 2 RAM blank, 1 RAM writable, 0 timers halt (reset 0). `tmr_step` = (1 << clock speed) + (2 << timer speed), which is 3 at reset.
- R8: A write to 0x00F1 sets the overlay enable from bit 7 and `tmr_run` from bits 2:0. For each timer whose run bit goes from 0 to 1, `tmr_restart` pulses during the write cycle.
- R9: `host_we` loads mailbox latch `host_sel`. Reads of 0x00F4–0x00F7 return latches 0–3. Bit 4 of a 0x00F1 write clears latches 0 and 1, and bit 5 clears latches 2 and 3. Core writes to 0x00F4–0x00F7 set byte 0–3 of `cpu_port_out`.
- R10: 0x00F2 stores the sound index and reads it back. Reads of 0x00F3 return `snd_rdata` with `snd_addr` = index bits 6:0. A write to 0x00F3 is dropped when index bit 7 is set.
- R11: 0x00F0, 0x00F1 and 0x00FA–0x00FC read as 0x00. 0x00F8 and 0x00F9 are read/write bytes. A write to 0x00FA+n pulses `tgt_we[n]` with `tgt_data`.
- R12: A read of 0x00FD+n returns timer n's 4-bit count (`tmr_count` bits 4n+3:4n) zero-extended, and pulses `tmr_rd_clr[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start an operation |
| op_kind | input | 2 | 0 internal, 1 read, 2 write |
| op_addr | input | 16 | Operation address |
| op_wdata | input | 8 | Write data |
| p_flag | input | 1 | Core P flag, locks configuration writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| rdata | output | 8 | Read result |
| ram_addr | output | 16 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| rom_idx | output | 6 | Boot ROM byte index |
| rom_data | input | 8 | Boot ROM byte |
| snd_addr | output | 7 | Sound register index |
| snd_we | output | 1 | Sound register write strobe |
| snd_wdata | output | 8 | Sound register write data |
| snd_rdata | input | 8 | Sound register read data |
| host_we | input | 1 | Host mailbox write |
| host_sel | input | 2 | Host mailbox select |
| host_wdata | input | 8 | Host mailbox data |
| cpu_port_out | output | 32 | Core-to-host mailbox bytes |
| tmr_run | output | 3 | Per-timer enables |
| tmr_restart | output | 3 | Per-timer restart pulses |
| tmr_global_en | output | 1 | Configuration timers enable |
| tmr_global_halt | output | 1 | Configuration timers halt |
| tmr_step | output | 5 | Prescaler step |
| tgt_we | output | 3 | Timer target write strobes |
| tgt_data | output | 8 | Timer target data |
| tmr_count | input | 12 | Three 4-bit timer counts |
| tmr_rd_clr | output | 3 | Timer count read strobes |

## Verification
A wrong phase count shows as a `busy` window other than 24 cycles. It also shows as a read result landing one cycle early or late, or as a write strobe outside the final cycle, and all of these are visible on the operation that exposes them. Corrupted configuration or control state shows on the very next read: an overlay read returns RAM data, a blanked read misses 0x5A, or a gated write still produces a RAM strobe. A lost or wrongly cleared mailbox latch, scratch byte or sound index shows on the first read of that register. A missed configuration lock appears at once on `tmr_step`.

// File: rtl/apu_bus_pkg.sv
package apu_bus_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int N_PORTS = 4;
    localparam int N_TMR   = 3;
    localparam int CNT_W   = 4;
    localparam int STEP_W  = 5;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } op_kind_e;

    // Field placement is what software writes, so it is kept.
    typedef struct packed {
        logic [1:0] clk_spd;
        logic [1:0] tmr_spd;
        logic       tmr_en;
        logic       ram_off;
        logic       ram_wr;
        logic       tmr_halt;
    } cfg_t;

    localparam cfg_t CFG_RST = 8'h0A;

    localparam logic [11:0]       PAGE_TAG    = 12'h00F;
    localparam logic [15:0]       ROM_BASE    = 16'hFFC0;
    localparam logic [DATA_W-1:0] BLANK_VALUE = 8'h5A;

    localparam logic [3:0] OFF_CFG  = 4'h0;
    localparam logic [3:0] OFF_CTL  = 4'h1;
    localparam logic [3:0] OFF_SIDX = 4'h2;
    localparam logic [3:0] OFF_SDAT = 4'h3;
    localparam logic [3:0] OFF_SCR0 = 4'h8;
    localparam logic [3:0] OFF_SCR1 = 4'h9;
    localparam logic [3:0] OFF_TGT0 = 4'hA;
    localparam logic [3:0] OFF_CNT0 = 4'hD;

    function automatic logic [STEP_W-1:0] step_of(cfg_t c);
        return (STEP_W'(1) << c.clk_spd) + (STEP_W'(2) << c.tmr_spd);
    endfunction

endpackage

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
    import apu_bus_pkg::*;
#(
    parameter int HALF = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  op_kind_e kind,
    output logic     accept,
    output logic     busy,
    output logic     last,
    output logic     rd_stb,
    output logic     wr_stb
);
    localparam int FULL = 2 * HALF;
    localparam int CW   = $clog2(FULL);

    logic [CW-1:0] cnt;
    op_kind_e      kind_q;

    assign accept = start && !busy;
    assign last   = busy && (cnt == CW'(FULL - 1));
    assign rd_stb = busy && (kind_q == OP_READ) && (cnt == CW'(HALF - 1));
    assign wr_stb = last && (kind_q == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            kind_q <= OP_IDLE;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= '0;
            kind_q <= kind;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      cnt  <= cnt + 1'b1;
        end
    end

    a_r1_count_advances: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
    a_r1_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

endmodule

// File: rtl/apu_mmio_regs.sv
module apu_mmio_regs
    import apu_bus_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_stb,
    input  logic                              rd_stb,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              p_flag,
    input  logic                              host_we,
    input  logic [1:0]                        host_sel,
    input  logic [DATA_W-1:0]                 host_wdata,
    output cfg_t                              cfg,
    output logic                              rom_en,
    output logic [N_TMR-1:0]                  tmr_run,
    output logic [N_TMR-1:0]                  tmr_restart,
    output logic [N_TMR-1:0]                  tgt_we,
    output logic [N_TMR-1:0]                  tmr_rd_clr,
    output logic [DATA_W-1:0]                 snd_idx,
    output logic                              snd_we,
    output logic [N_PORTS-1:0][DATA_W-1:0]    host_latch,
    output logic [N_PORTS-1:0][DATA_W-1:0]    cpu_port,
    output logic [1:0][DATA_W-1:0]            scratch
);
    logic       page_hit, wr_pg, rd_pg, ctl_wr;
    logic [3:0] off;

    assign page_hit = (addr[15:4] == PAGE_TAG);
    assign off      = addr[3:0];
    assign wr_pg    = wr_stb && page_hit;
    assign rd_pg    = rd_stb && page_hit;
    assign ctl_wr   = wr_pg && (off == OFF_CTL);

    assign snd_we      = wr_pg && (off == OFF_SDAT) && !snd_idx[7];
    assign tmr_restart = ctl_wr ? (wdata[N_TMR-1:0] & ~tmr_run) : '0;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        assign tgt_we[t]     = wr_pg && (off == OFF_TGT0 + 4'(t));
        assign tmr_rd_clr[t] = rd_pg && (off == OFF_CNT0 + 4'(t));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= CFG_RST;
            rom_en     <= 1'b1;
            tmr_run    <= '0;
            snd_idx    <= '0;
            scratch    <= '0;
            cpu_port   <= '0;
            host_latch <= '0;
        end else begin
            if (wr_pg) begin
                case (off)
                    OFF_CFG:  if (!p_flag) cfg <= cfg_t'(wdata);
                    OFF_CTL: begin
                        rom_en  <= wdata[7];
                        tmr_run <= wdata[N_TMR-1:0];
                    end
                    OFF_SIDX: snd_idx    <= wdata;
                    OFF_SCR0: scratch[0] <= wdata;
                    OFF_SCR1: scratch[1] <= wdata;
                    default: if (off[3:2] == 2'b01) cpu_port[off[1:0]] <= wdata;
                endcase
            end
            if (ctl_wr && wdata[4]) begin
                host_latch[0] <= '0;
                host_latch[1] <= '0;
            end
            if (ctl_wr && wdata[5]) begin
                host_latch[2] <= '0;
                host_latch[3] <= '0;
            end
            if (host_we) host_latch[host_sel] <= host_wdata;
        end
    end

    a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_pg && off == OFF_CFG && p_flag) |=> $stable(cfg));
    a_r8_restart_runs: assert property (@(posedge clk) disable iff (rst)
        (|tmr_restart) |=> ((tmr_run & $past(tmr_restart)) == $past(tmr_restart)));

endmodule

// File: rtl/apu_read_mux.sv
module apu_read_mux
    import apu_bus_pkg::*;
(
    input  logic [ADDR_W-1:0]              addr,
    input  cfg_t                           cfg,
    input  logic                           rom_en,
    input  logic [DATA_W-1:0]              snd_idx,
    input  logic [DATA_W-1:0]              snd_rdata,
    input  logic [N_PORTS-1:0][DATA_W-1:0] host_latch,
    input  logic [1:0][DATA_W-1:0]         scratch,
    input  logic [N_TMR*CNT_W-1:0]         tmr_count,
    input  logic [DATA_W-1:0]              ram_rdata,
    input  logic [DATA_W-1:0]              rom_data,
    output logic [DATA_W-1:0]              data
);
    logic [3:0] off;
    assign off = addr[3:0];

    always_comb begin
        data = cfg.ram_off ? BLANK_VALUE : ram_rdata;
        if (rom_en && addr >= ROM_BASE) data = rom_data;
        if (addr[15:4] == PAGE_TAG) begin
            case (off)
                OFF_SIDX: data = snd_idx;
                OFF_SDAT: data = snd_rdata;
                OFF_SCR0: data = scratch[0];
                OFF_SCR1: data = scratch[1];
                4'hD:     data = DATA_W'(tmr_count[CNT_W-1:0]);
                4'hE:     data = DATA_W'(tmr_count[2*CNT_W-1:CNT_W]);
                4'hF:     data = DATA_W'(tmr_count[3*CNT_W-1:2*CNT_W]);
                default:  data = (off[3:2] == 2'b01) ? host_latch[off[1:0]] : '0;
            endcase
        end
    end

endmodule

// File: rtl/apu_bus_decoder.sv
module apu_bus_decoder
    import apu_bus_pkg::*;
#(
    parameter int HALF = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_start,
    input  logic [1:0]               op_kind,
    input  logic [ADDR_W-1:0]        op_addr,
    input  logic [DATA_W-1:0]        op_wdata,
    input  logic                     p_flag,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic                     ram_we,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [5:0]               rom_idx,
    input  logic [DATA_W-1:0]        rom_data,
    output logic [6:0]               snd_addr,
    output logic                     snd_we,
    output logic [DATA_W-1:0]        snd_wdata,
    input  logic [DATA_W-1:0]        snd_rdata,
    input  logic                     host_we,
    input  logic [1:0]               host_sel,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [N_PORTS*DATA_W-1:0] cpu_port_out,
    output logic [N_TMR-1:0]         tmr_run,
    output logic [N_TMR-1:0]         tmr_restart,
    output logic                     tmr_global_en,
    output logic                     tmr_global_halt,
    output logic [STEP_W-1:0]        tmr_step,
    output logic [N_TMR-1:0]         tgt_we,
    output logic [DATA_W-1:0]        tgt_data,
    input  logic [N_TMR*CNT_W-1:0]   tmr_count,
    output logic [N_TMR-1:0]         tmr_rd_clr
);
    logic accept, rd_stb, wr_stb, rom_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, snd_idx, rd_val;
    cfg_t cfg;
    logic [N_PORTS-1:0][DATA_W-1:0] host_latch, cpu_port;
    logic [1:0][DATA_W-1:0] scratch;

    bus_phase_seq #(.HALF(HALF)) u_seq (
        .clk(clk), .rst(rst), .start(op_start), .kind(op_kind_e'(op_kind)),
        .accept(accept), .busy(busy), .last(done), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                addr_q  <= op_addr;
                wdata_q <= op_wdata;
            end
            if (rd_stb) rdata <= rd_val;
        end
    end

    apu_mmio_regs u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr_q),
        .wdata(wdata_q), .p_flag(p_flag), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .cfg(cfg), .rom_en(rom_en), .tmr_run(tmr_run),
        .tmr_restart(tmr_restart), .tgt_we(tgt_we), .tmr_rd_clr(tmr_rd_clr),
        .snd_idx(snd_idx), .snd_we(snd_we), .host_latch(host_latch),
        .cpu_port(cpu_port), .scratch(scratch)
    );

    apu_read_mux u_mux (
        .addr(addr_q), .cfg(cfg), .rom_en(rom_en), .snd_idx(snd_idx),
        .snd_rdata(snd_rdata), .host_latch(host_latch), .scratch(scratch),
        .tmr_count(tmr_count), .ram_rdata(ram_rdata), .rom_data(rom_data),
        .data(rd_val)
    );

    assign ram_addr        = addr_q;
    assign ram_wdata       = wdata_q;
    assign ram_we          = wr_stb && cfg.ram_wr && !cfg.ram_off;
    assign rom_idx         = addr_q[5:0];
    assign snd_addr        = snd_idx[6:0];
    assign snd_wdata       = wdata_q;
    assign tgt_data        = wdata_q;
    assign cpu_port_out    = cpu_port;
    assign tmr_global_en   = cfg.tmr_en;
    assign tmr_global_halt = cfg.tmr_halt;
    assign tmr_step        = step_of(cfg);

    a_r2_writes_at_end: assert property (@(posedge clk) disable iff (rst)
        (ram_we || snd_we || (|tgt_we)) |-> done);
    a_r10_snd_write_addr: assert property (@(posedge clk) disable iff (rst)
        snd_we |-> (ram_addr == 16'h00F3));
    a_r12_count_read: assert property (@(posedge clk) disable iff (rst)
        (|tmr_rd_clr) |=> (rdata[7:4] == 4'h0));
    a_r1_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && op_start && !done) |=> busy);

endmodule

// File: tb/tb_apu_bus_decoder.sv
module tb_apu_bus_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic op_start = 0, p_flag = 0, host_we = 0;
    logic [1:0] op_kind = 0, host_sel = 0;
    logic [15:0] op_addr = 0;
    logic [7:0] op_wdata = 0, host_wdata = 0;
    logic busy, done, ram_we, snd_we;
    logic [7:0] rdata, ram_wdata, ram_rdata, rom_data, snd_wdata, snd_rdata, tgt_data;
    logic [15:0] ram_addr;
    logic [5:0] rom_idx;
    logic [6:0] snd_addr;
    logic [31:0] cpu_port_out;
    logic [2:0] tmr_run, tmr_restart, tgt_we, tmr_rd_clr;
    logic tmr_global_en, tmr_global_halt;
    logic [4:0] tmr_step;
    logic [11:0] tmr_count = 12'hA53;

    assign ram_rdata = ram_addr[7:0] ^ ram_addr[15:8] ^ 8'h3C;
    assign rom_data  = {2'b10, rom_idx};
    assign snd_rdata = {1'b0, snd_addr} ^ 8'hA0;

    apu_bus_decoder dut (.*);

    int checks = 0, errors = 0;
    int ram_wcnt = 0, snd_wcnt = 0, tgt_wcnt = 0, rs_cnt = 0, clr_cnt = 0;
    logic [15:0] last_ram_a;
    logic [7:0] last_ram_d, last_snd_d, last_tgt_d;
    logic [6:0] last_snd_a;
    logic [2:0] last_tgt, last_rs, last_clr;

    always @(posedge clk) begin
        if (ram_we) begin ram_wcnt++; last_ram_a = ram_addr; last_ram_d = ram_wdata; end
        if (snd_we) begin snd_wcnt++; last_snd_a = snd_addr; last_snd_d = snd_wdata; end
        if (|tgt_we) begin tgt_wcnt++; last_tgt = tgt_we; last_tgt_d = tgt_data; end
        if (|tmr_restart) begin rs_cnt++; last_rs = tmr_restart; end
        if (|tmr_rd_clr) begin clr_cnt++; last_clr = tmr_rd_clr; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    int blen, wr_at, mid12, mid13;
    logic poke = 0;

    task automatic op(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                      output logic [7:0] res);
        @(negedge clk);
        op_start = 1; op_kind = k; op_addr = a; op_wdata = d;
        @(negedge clk);
        op_start = 0;
        blen = 0; wr_at = 0; mid12 = -1; mid13 = -1;
        while (busy) begin
            blen++;
            if (blen == 12) mid12 = int'(rdata);
            if (blen == 13) mid13 = int'(rdata);
            if ((ram_we || snd_we || (|tgt_we)) && wr_at == 0) wr_at = blen;
            if (poke && blen == 5) begin op_start = 1; op_kind = 2'd2; op_addr = 16'h0500; end
            if (poke && blen == 6) op_start = 0;
            @(negedge clk);
        end
        res = rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] r;
        op(2'd2, a, d, r);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] e);
        logic [7:0] r;
        op(2'd1, a, 8'h00, r);
        chk(req, {24'h0, r}, {24'h0, e});
    endtask

    task automatic host_put(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    // {kind, addr, wdata, expected}; kind 1 read, 2 write
    localparam int NV = 18;
    localparam logic [33:0] VEC [NV] = '{
        {2'd2, 16'h00F8, 8'h3C, 8'h00},  // R11 scratch 0
        {2'd1, 16'h00F8, 8'h00, 8'h3C},
        {2'd2, 16'h00F9, 8'hC5, 8'h00},  // R11 scratch 1
        {2'd1, 16'h00F9, 8'h00, 8'hC5},
        {2'd1, 16'h00F8, 8'h00, 8'h3C},
        {2'd2, 16'h00F2, 8'h15, 8'h00},  // R10 index
        {2'd1, 16'h00F2, 8'h00, 8'h15},
        {2'd1, 16'h00F3, 8'h00, 8'hB5},  // R10 window read
        {2'd1, 16'h00F0, 8'h00, 8'h00},  // R11 write-only
        {2'd1, 16'h00F1, 8'h00, 8'h00},
        {2'd1, 16'h00FA, 8'h00, 8'h00},
        {2'd1, 16'h00FC, 8'h00, 8'h00},
        {2'd1, 16'h1234, 8'h00, 8'h1A},  // R5 plain RAM
        {2'd1, 16'hFFC5, 8'h00, 8'h85},  // R3 overlay
        {2'd1, 16'hFFFF, 8'h00, 8'hBF},  // R3 overlay top
        {2'd1, 16'hFFBF, 8'h00, 8'h7C},  // R3 just below overlay
        {2'd1, 16'h00FD, 8'h00, 8'h03},  // R12 timer 0 count
        {2'd1, 16'h00FF, 8'h00, 8'h0A}   // R12 timer 2 count
    };

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk("R1 busy at reset", {31'h0, busy}, 32'h0);
        chk("R7 step at reset", {27'h0, tmr_step}, 32'd3);
        chk("R7 timers enable at reset", {31'h0, tmr_global_en}, 32'h1);
        chk("R7 halt at reset", {31'h0, tmr_global_halt}, 32'h0);
        chk("R8 run at reset", {29'h0, tmr_run}, 32'h0);
        chk("R9 ports at reset", cpu_port_out, 32'h0);
        rd_chk("R10 index at reset", 16'h00F2, 8'h00);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][33:32], VEC[i][31:16], VEC[i][15:8], r);
            if (VEC[i][33:32] == 2'd1) chk("R3/R10/R11/R12 vector read", {24'h0, r}, {24'h0, VEC[i][7:0]});
        end

        // R1 / R2 timing
        wr(16'h00F8, 8'h11);
        chk("R1 write busy length", blen, 24);
        chk("R2 write strobe in last cycle", wr_at, 24);
        rd_chk("R11 scratch reload", 16'h00F8, 8'h11);
        chk("R1 read busy length", blen, 24);
        op(2'd1, 16'h1234, 8'h00, r);
        chk("R2 rdata before 12th cycle end", mid12, 32'h11);
        chk("R2 rdata after 12th cycle end", mid13, 32'h1A);
        n = ram_wcnt;
        op(2'd0, 16'h0600, 8'h99, r);
        chk("R1 internal busy length", blen, 24);
        chk("R1 internal no RAM write", ram_wcnt, n);
        poke = 1;
        op(2'd1, 16'h1234, 8'h00, r);
        poke = 0;
        chk("R1 start ignored while busy, length", blen, 24);
        @(negedge clk);
        chk("R1 start ignored while busy, stays idle", {31'h0, busy}, 32'h0);
        chk("R1 ignored start made no write", ram_wcnt, n);

        // R6 every write reaches RAM
        wr(16'h00F9, 8'h66);
        chk("R6 control write to RAM addr", {16'h0, last_ram_a}, 32'h00F9);
        chk("R6 control write to RAM data", {24'h0, last_ram_d}, 32'h66);

        // R7 configuration
        p_flag = 1;
        wr(16'h00F0, 8'hFF);
        p_flag = 0;
        chk("R7 locked write ignored step", {27'h0, tmr_step}, 32'd3);
        chk("R7 locked write ignored halt", {31'h0, tmr_global_halt}, 32'h0);
        wr(16'h00F0, 8'h5A);
        chk("R7 step 1/1", {27'h0, tmr_step}, 32'd6);
        wr(16'h00F0, 8'h3B);
        chk("R7 step 0/3", {27'h0, tmr_step}, 32'd17);
        chk("R7 halt field", {31'h0, tmr_global_halt}, 32'h1);
        chk("R7 enable field", {31'h0, tmr_global_en}, 32'h1);

        // R5 blanking and write gating
        wr(16'h00F0, 8'h06);
        rd_chk("R5 blanked RAM read", 16'h1234, 8'h5A);
        rd_chk("R3 overlay above blank", 16'hFFC5, 8'h85);
        n = ram_wcnt;
        wr(16'h0200, 8'h12);
        wr(16'h00F0, 8'h00);
        chk("R5 no RAM write while blanked", ram_wcnt, n);
        rd_chk("R5 unblanked read", 16'h1234, 8'h1A);
        wr(16'h0300, 8'h33);
        wr(16'h00F0, 8'h02);
        chk("R5 no RAM write while not writable", ram_wcnt, n);
        wr(16'h0400, 8'h44);
        chk("R5 write resumes", ram_wcnt, n + 1);
        chk("R5 write addr", {16'h0, last_ram_a}, 32'h0400);

        // R4 overlay range writes
        wr(16'hFFC5, 8'h77);
        chk("R4 overlay write addr", {16'h0, last_ram_a}, 32'hFFC5);
        chk("R4 overlay write data", {24'h0, last_ram_d}, 32'h77);
        rd_chk("R4 overlay still read from ROM", 16'hFFC5, 8'h85);

        // R8 control
        n = rs_cnt;
        wr(16'h00F1, 8'h05);
        chk("R8 run bits", {29'h0, tmr_run}, 32'h5);
        chk("R8 restart pulse", {29'h0, last_rs}, 32'h5);
        rd_chk("R3 overlay off reads RAM", 16'hFFC5, 8'h06);
        wr(16'h00F1, 8'h07);
        chk("R8 restart only new timer", {29'h0, last_rs}, 32'h2);
        chk("R8 restart count", rs_cnt, n + 2);
        wr(16'h00F1, 8'h87);
        chk("R8 no restart when already running", rs_cnt, n + 2);
        rd_chk("R3 overlay back on", 16'hFFC5, 8'h85);

        // R9 mailboxes
        host_put(2'd0, 8'hA1);
        host_put(2'd1, 8'hB2);
        host_put(2'd2, 8'hC3);
        host_put(2'd3, 8'hD4);
        rd_chk("R9 latch 0", 16'h00F4, 8'hA1);
        rd_chk("R9 latch 3", 16'h00F7, 8'hD4);
        wr(16'h00F1, 8'h97);
        rd_chk("R9 clear low pair 0", 16'h00F4, 8'h00);
        rd_chk("R9 clear low pair 1", 16'h00F5, 8'h00);
        rd_chk("R9 high pair kept", 16'h00F6, 8'hC3);
        wr(16'h00F1, 8'hA7);
        rd_chk("R9 clear high pair 2", 16'h00F6, 8'h00);
        rd_chk("R9 clear high pair 3", 16'h00F7, 8'h00);
        wr(16'h00F6, 8'h9E);
        chk("R9 core port byte 2", cpu_port_out, 32'h009E_0000);
        rd_chk("R9 core write leaves latch", 16'h00F6, 8'h00);

        // R10 indirect window
        n = snd_wcnt;
        wr(16'h00F2, 8'h85);
        wr(16'h00F3, 8'h11);
        chk("R10 mirror write dropped", snd_wcnt, n);
        rd_chk("R10 mirror read", 16'h00F3, 8'hA5);
        rd_chk("R10 index full readback", 16'h00F2, 8'h85);
        wr(16'h00F2, 8'h05);
        wr(16'h00F3, 8'h22);
        chk("R10 write strobe at last cycle", wr_at, 24);
        chk("R10 write count", snd_wcnt, n + 1);
        chk("R10 write addr/data", {17'h0, last_snd_a, last_snd_d}, {17'h0, 7'h05, 8'h22});

        // R11 timer targets
        n = tgt_wcnt;
        wr(16'h00FB, 8'h40);
        chk("R11 target strobe", {29'h0, last_tgt}, 32'h2);
        chk("R11 target data", {24'h0, last_tgt_d}, 32'h40);
        chk("R11 target count", tgt_wcnt, n + 1);
        rd_chk("R11 target reads zero", 16'h00FB, 8'h00);

        // R12 count read
        n = clr_cnt;
        rd_chk("R12 timer 1 count", 16'h00FE, 8'h05);
        chk("R12 read strobe", {29'h0, last_clr}, 32'h2);
        chk("R12 read strobe count", clr_cnt, n + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule